// File: doc/BRIEF.md
# Power-on reset time-out sequencer

This block keeps a processor core in reset after a power-on or brown-out event, and after a wake from a power-managed state, until its clock can be trusted. It steps through as many as three timed phases, always in the same order. The first is a power-up delay counted on ticks of the slow internal RC clock. The second is a start-up count of external oscillator cycles. The third is a lock wait for the PLL, also counted on RC ticks. The oscillator mode, a power-up-delay disable bit and the cause of the reset decide which of these phases run.

The block runs on one system clock. The RC clock and the external oscillator reach it as single-cycle tick enables, `rc_tick` and `osc_tick`. The time-outs are counted from the power-on event and not from the external reset pin. The pin, once synchronised, is simply ORed into the core reset. If the pin is held low until every phase has expired, the core leaves reset within two cycles of the pin's release.

Top module: `por_tmo_seq`

## Requirements
- R1: While `rst_n` is low, `phase` is 0 (idle) and `core_rst` is 1.
- R2: While `por_evt` is high, `phase` is 0 (idle) from the next cycle on, whatever phase was running. The first applicable phase starts on the first clock edge at which `por_evt` is low.
- R3: When `pwrt_dis` is 0, a power-on sequence starts with the power-up delay phase (`phase` = 1). That phase lasts exactly PWRT_TICKS cycles in which `rc_tick` is high. When `pwrt_dis` is 1, phase 1 is never entered.
- R4: The oscillator start-up phase (`phase` = 2) lasts exactly OST_CYCLES cycles in which `osc_tick` is high. It runs only in the crystal and resonator modes (`osc_mode` 0 = LP, 1 = XT, 2 = HS, 3 = HS with PLL), and it always comes after phase 1. Phases never step backwards except on a restart.
- R5: Only in mode 3 does a PLL lock phase (`phase` = 3) follow phase 2. It lasts exactly PLL_TICKS cycles in which `rc_tick` is high.
- R6: In modes 4 to 7 (external clock, RC, internal oscillator) with `pwrt_dis` = 1, the block goes from idle straight to done on the first edge, with no time-out.
- R7: A `pm_exit` pulse while `phase` is 4 (done) starts phase 2 in modes 0 to 3, followed by phase 3 in mode 3, and never runs phase 1. In modes 4 to 7, or in any other phase, `pm_exit` has no effect on the phase sequence or its tick counts.
- R8: `core_rst` is 1 whenever `phase` is not 4, and whenever the synchronised `mclr_n` is low. After `mclr_n` rises it stays 1 for one more cycle and drops on the second edge.
- R9: The phases advance whether or not `mclr_n` is held low.
- R10: `phase` only takes the codes 0 idle, 1 power-up delay, 2 oscillator start-up, 3 PLL lock, 4 done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_evt | input | 1 | Power-on or brown-out event, held high for the length of the pulse |
| pm_exit | input | 1 | One-cycle request to leave a power-managed state |
| mclr_n | input | 1 | External reset pin, active low, asynchronous |
| osc_mode | input | 3 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 HS with PLL, 4 to 7 non-crystal |
| pwrt_dis | input | 1 | 1 skips the power-up delay phase |
| rc_tick | input | 1 | One-cycle tick from the internal RC clock |
| osc_tick | input | 1 | One-cycle tick per external oscillator cycle |
| core_rst | output | 1 | Reset held on the processor core |
| phase | output | 3 | Current phase code |

## Verification
A phase change shows on `phase` one edge after the tick that ends the previous phase. A start after `por_evt` falls, or after a `pm_exit` pulse, also shows one edge later. The bench reads `phase` on the falling edge before it drives that edge's ticks. Each tick it drives is credited to the phase in force at the next rising edge, so every phase can be checked against an exact tick count rather than a cycle window. `core_rst` follows `phase` in the same cycle, but it trails a rising `mclr_n` by two edges. The bench therefore samples it one and two falling edges after the release.

// File: rtl/por_tmo_pkg.sv
package por_tmo_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PWRT = 3'd1,
    PH_OST  = 3'd2,
    PH_PLL  = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

  localparam logic [2:0] MODE_HSPLL = 3'd3;

  // Modes 0..3 use a crystal or resonator and need the start-up count.
  function automatic logic needs_ost(input logic [2:0] mode);
    return ~mode[2];
  endfunction

  function automatic logic needs_pll(input logic [2:0] mode);
    return mode == MODE_HSPLL;
  endfunction

endpackage

// File: rtl/por_tmo_sync.sv
module por_tmo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  // Reset value 0 keeps the core held until the pin is seen high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/por_tmo_cnt.sv
module por_tmo_cnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] last,
  output logic          hit
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign hit = en && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (en)  cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/por_tmo_fsm.sv
module por_tmo_fsm
  import por_tmo_pkg::*;
#(
  parameter int PWRT_TICKS = 2048,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 63,
  parameter int CW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_evt,
  input  logic          pm_exit,
  input  logic [2:0]    osc_mode,
  input  logic          pwrt_dis,
  input  logic          rc_tick,
  input  logic          osc_tick,
  input  logic          hit,
  output phase_e        phase_q,
  output logic          cnt_en,
  output logic          cnt_clr,
  output logic [CW-1:0] cnt_last
);
  localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYCLES - 1);
  localparam logic [CW-1:0] PLL_LAST  = CW'(PLL_TICKS - 1);

  phase_e phase_d;
  phase_e first_ph;
  logic   crystal;
  logic   pll_on;

  assign crystal = needs_ost(osc_mode);
  assign pll_on  = needs_pll(osc_mode);

  always_comb begin
    if (!pwrt_dis)    first_ph = PH_PWRT;
    else if (crystal) first_ph = PH_OST;
    else              first_ph = PH_DONE;
  end

  // Tick source and terminal count per phase.
  always_comb begin
    cnt_en   = 1'b0;
    cnt_last = '0;
    unique case (phase_q)
      PH_PWRT: begin cnt_en = rc_tick;  cnt_last = PWRT_LAST; end
      PH_OST:  begin cnt_en = osc_tick; cnt_last = OST_LAST;  end
      PH_PLL:  begin cnt_en = rc_tick;  cnt_last = PLL_LAST;  end
      default: begin cnt_en = 1'b0;     cnt_last = '0;        end
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: phase_d = first_ph;
      PH_PWRT: if (hit) phase_d = crystal ? PH_OST : PH_DONE;
      PH_OST:  if (hit) phase_d = pll_on ? PH_PLL : PH_DONE;
      PH_PLL:  if (hit) phase_d = PH_DONE;
      PH_DONE: if (pm_exit && crystal) phase_d = PH_OST;
      default: phase_d = PH_IDLE;
    endcase
    if (por_evt) phase_d = PH_IDLE;
  end

  assign cnt_clr = (phase_d != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/por_tmo_seq.sv
module por_tmo_seq
  import por_tmo_pkg::*;
#(
  parameter int PWRT_TICKS  = 2048,
  parameter int OST_CYCLES  = 1024,
  parameter int PLL_TICKS   = 63,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_evt,
  input  logic       pm_exit,
  input  logic       mclr_n,
  input  logic [2:0] osc_mode,
  input  logic       pwrt_dis,
  input  logic       rc_tick,
  input  logic       osc_tick,
  output logic       core_rst,
  output logic [2:0] phase
);
  localparam int MAX_AB = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int MAX_N  = (MAX_AB > PLL_TICKS) ? MAX_AB : PLL_TICKS;
  localparam int CW     = $clog2(MAX_N + 1);

  logic          pin_ok;
  logic          cnt_en;
  logic          cnt_clr;
  logic          hit;
  logic [CW-1:0] cnt_last;
  phase_e        phase_q;

  por_tmo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mclr_n),
    .q     (pin_ok)
  );

  por_tmo_fsm #(
    .PWRT_TICKS (PWRT_TICKS),
    .OST_CYCLES (OST_CYCLES),
    .PLL_TICKS  (PLL_TICKS),
    .CW         (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_evt  (por_evt),
    .pm_exit  (pm_exit),
    .osc_mode (osc_mode),
    .pwrt_dis (pwrt_dis),
    .rc_tick  (rc_tick),
    .osc_tick (osc_tick),
    .hit      (hit),
    .phase_q  (phase_q),
    .cnt_en   (cnt_en),
    .cnt_clr  (cnt_clr),
    .cnt_last (cnt_last)
  );

  por_tmo_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .last  (cnt_last),
    .hit   (hit)
  );

  assign phase    = phase_q;
  assign core_rst = (phase_q != PH_DONE) || !pin_ok;
endmodule

// File: rtl/por_tmo_chk.sv
module por_tmo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_evt,
  input logic       pm_exit,
  input logic       mclr_n,
  input logic [2:0] osc_mode,
  input logic       pwrt_dis,
  input logic       core_rst,
  input logic [2:0] phase
);
  p_evt_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> phase == 3'd0);

  p_skip_pwrt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !por_evt && pwrt_dis) |=> phase != 3'd1);

  p_no_ost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd2 && osc_mode[2]) |=> phase != 3'd2);

  p_pll_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd3 && osc_mode != 3'd3) |=> phase != 3'd3);

  p_done_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && !por_evt && !(pm_exit && !osc_mode[2])) |=> phase == 3'd4);

  p_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 3'd4 |-> core_rst);

  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_n |=> ##1 core_rst);

  p_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd4);
endmodule

bind por_tmo_seq por_tmo_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .por_evt  (por_evt),
  .pm_exit  (pm_exit),
  .mclr_n   (mclr_n),
  .osc_mode (osc_mode),
  .pwrt_dis (pwrt_dis),
  .core_rst (core_rst),
  .phase    (phase)
);

// File: tb/tb_por_tmo_seq.sv
`timescale 1ns/1ps
module tb_por_tmo_seq;
  localparam int P = 40;
  localparam int O = 20;
  localparam int L = 7;

  logic       clk = 1'b0;
  logic       rst_n, por_evt, pm_exit, mclr_n, pwrt_dis, rc_tick, osc_tick;
  logic [2:0] osc_mode;
  logic       core_rst;
  logic [2:0] phase;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  por_tmo_seq #(.PWRT_TICKS(P), .OST_CYCLES(O), .PLL_TICKS(L)) dut (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .pm_exit(pm_exit),
    .mclr_n(mclr_n), .osc_mode(osc_mode), .pwrt_dis(pwrt_dis),
    .rc_tick(rc_tick), .osc_tick(osc_tick), .core_rst(core_rst), .phase(phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected ticks consumed in a phase, from R3/R4/R5/R7.
  function automatic int exp_ticks(input int ph, input logic [2:0] m,
                                   input bit dis, input bit pm);
    case (ph)
      1:       return (!pm && !dis) ? P : 0;
      2:       return (!m[2]) ? O : 0;
      3:       return (m == 3'd3) ? L : 0;
      default: return 0;
    endcase
  endfunction

  task automatic run_seq(input bit pm, input bit hold_pin);
    int n_pw = 0, n_os = 0, n_pl = 0, it = 0;
    bit bad_hold = 0, bad_order = 0;
    logic [2:0] p, last;
    last = 3'd0;
    if (hold_pin) begin mclr_n = 1'b0; repeat (2) @(negedge clk); end
    if (!pm) begin por_evt = 1'b1; repeat (3) @(negedge clk); end
    forever begin
      p = phase;
      if (p != 3'd4 && !core_rst) bad_hold = 1;
      if (it > 0 && last != 3'd4 && p < last) bad_order = 1;
      last = p;
      if (it > 0 && p == 3'd4) break;
      if (it == 0) begin
        if (pm) pm_exit = 1'b1; else por_evt = 1'b0;
      end else begin
        pm_exit = !pm && ($urandom % 8 == 0);   // R7: ignored outside done
      end
      rc_tick  = ($urandom % 4) != 0;
      osc_tick = ($urandom % 3) != 0;
      if (p == 3'd1 && rc_tick)  n_pw++;
      if (p == 3'd2 && osc_tick) n_os++;
      if (p == 3'd3 && rc_tick)  n_pl++;
      it++;
      if (it > 5000) begin chk(0, "R4 timeout", it, 0); break; end
      @(negedge clk);
    end
    pm_exit = 1'b0;
    chk(n_pw == exp_ticks(1, osc_mode, pwrt_dis, pm), "R3 pwrt ticks", n_pw, exp_ticks(1, osc_mode, pwrt_dis, pm));
    chk(n_os == exp_ticks(2, osc_mode, pwrt_dis, pm), "R4 ost ticks", n_os, exp_ticks(2, osc_mode, pwrt_dis, pm));
    chk(n_pl == exp_ticks(3, osc_mode, pwrt_dis, pm), "R5 pll ticks", n_pl, exp_ticks(3, osc_mode, pwrt_dis, pm));
    chk(!bad_hold, "R8 held while active", bad_hold, 0);
    chk(!bad_order, "R4 phase order", bad_order, 0);
    if (!pm && osc_mode[2] && pwrt_dis)
      chk(it == 1, "R6 no time-out", it, 1);
    if (hold_pin) begin
      chk(core_rst == 1'b1, "R9 pin holds after phases", core_rst, 1);
      mclr_n = 1'b1;
      @(negedge clk);
      chk(core_rst == 1'b1, "R8 one edge after pin", core_rst, 1);
      @(negedge clk);
      chk(core_rst == 1'b0, "R8 two edges after pin", core_rst, 0);
    end else begin
      chk(core_rst == 1'b0, "R8 released when done", core_rst, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 1'b0; por_evt = 1'b1; pm_exit = 1'b0; mclr_n = 1'b1;
    osc_mode = 3'd2; pwrt_dis = 1'b0; rc_tick = 1'b0; osc_tick = 1'b0;
    repeat (4) @(negedge clk);
    chk(phase == 3'd0, "R1 reset phase", phase, 0);
    chk(core_rst == 1'b1, "R1 reset core_rst", core_rst, 1);
    rst_n = 1'b1;
    repeat (20) begin rc_tick = 1'b1; osc_tick = 1'b1; @(negedge clk); end
    chk(phase == 3'd0, "R2 idle while event high", phase, 0);

    // Restart in the middle of the power-up delay.
    por_evt = 1'b0;
    repeat (10) @(negedge clk);
    chk(phase == 3'd1, "R2 pwrt running", phase, 1);
    por_evt = 1'b1;
    @(negedge clk);
    chk(phase == 3'd0, "R2 restart to idle", phase, 0);
    por_evt = 1'b0;
    @(negedge clk);
    chk(phase == 3'd1, "R2 first phase after event", phase, 1);

    // Directed corners.
    osc_mode = 3'd3; pwrt_dis = 1'b0; run_seq(0, 1'b0);
    run_seq(1, 1'b0);                              // R7 wake with PLL
    osc_mode = 3'd5; pwrt_dis = 1'b1; run_seq(0, 1'b0);   // R6
    run_seq(1, 1'b0);                              // R7 ignored in non-crystal
    chk(phase == 3'd4, "R7 wake ignored", phase, 4);
    osc_mode = 3'd0; pwrt_dis = 1'b1; run_seq(0, 1'b1);   // R9 pin held

    for (int t = 0; t < 24; t++) begin
      osc_mode = 3'($urandom % 8);
      pwrt_dis = 1'($urandom % 2);
      run_seq(0, ($urandom % 4) == 0);
      if ($urandom % 2) run_seq(1, 1'b0);
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule